// File: doc/BRIEF.md
# XGA Raster Timing Generator with Colour Expander

This block produces the horizontal and vertical timing of a 1024x768 display. Each line is 1344 pixel clocks long and each frame is 806 lines long. Alongside the timing it turns 16-bit packed pixels into 30-bit colour words for the display side. Pixels come from a frame-buffer reader over a valid/ready stream. The block asks for exactly one pixel per pixel clock while the raster is inside the visible area. It never asks for a pixel during blanking.

All display-side outputs are registered and aligned with each other. Sync, blank, the start-of-frame pulse and the colour word that belong to raster position (h, v) appear one clock after the counters stand at that position. The ready signal is the exception: it comes straight from the counters in the same cycle, so a pixel is accepted in the cycle the position is active.

If the reader has no pixel ready during a visible clock, the block shows black for that pixel and raises a sticky underflow flag. The flag stays up until the next frame begins.

Top module: `xga_raster_expander`

## Requirements
- R1: Each line lasts H_ACT+H_FP+H_SW+H_BP clocks (default 1024+24+136+160 = 1344). `blank` is 0 exactly for positions with h < H_ACT and v < V_ACT. Outputs appear one clock after the counter position they describe.
- R2: `hsync_n` is active low. It is 0 for positions with H_ACT+H_FP <= h < H_ACT+H_FP+H_SW (default 1048 to 1183) on every line.
- R3: Each frame lasts V_ACT+V_FP+V_SW+V_BP lines (default 768+3+6+29 = 806). `vsync_n` is active low and is 0 for whole lines with V_ACT+V_FP <= v < V_ACT+V_FP+V_SW (default lines 771 to 776).
- R4: `px_ready` is 1 in the same cycle whenever reset is released and the current position is visible, and is 0 otherwise. A pixel is taken when `px_ready` and `px_valid` are both 1.
- R5: A taken pixel holds red in bits 15:11, green in bits 10:5 and blue in bits 4:0. On the next clock `rgb` carries red in bits 29:20, green in bits 19:10 and blue in bits 9:0. Each channel is widened by repeating its upper bits below it, so red r becomes {r,r}, green g becomes {g,g[5:2]} and blue b becomes {b,b]}, and full scale gives 0x3FF.
- R6: `rgb` is 0 for every blanked position.
- R7: When a visible position has `px_valid` at 0, that position's `rgb` is 0 and `underflow` is 1 from that output onward. The flag stays set until the output for position (0,0) of the next frame. It is re-evaluated there from that pixel alone.
- R8: `sof` is 1 for exactly one clock, together with the output for position (0,0).
- R9: While `rst_n` is 0: `hsync_n`=1, `vsync_n`=1, `blank`=1, `sof`=0, `rgb`=0, `underflow`=0 and `px_ready`=0. The raster restarts at (0,0) after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_data | input | 16 | Packed 5:6:5 pixel from the frame-buffer reader |
| px_valid | input | 1 | `px_data` holds a pixel |
| px_ready | output | 1 | Block takes a pixel this cycle |
| rgb | output | 30 | Expanded colour, 10 bits per channel |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the visible area |
| sof | output | 1 | One-clock start-of-frame marker |
| underflow | output | 1 | Sticky: a visible pixel was missing in this frame |

## Verification
The assertions check relations on every cycle:
- `sof` lasts a single clock.
- Both syncs fall inside blanking.
- Blanked output is black.
- A ready cycle yields an unblanked output next.
- A starved visible pixel yields black with the flag set.
- The flag only drops at a start of frame.

Only the bench's scenarios can show the exact sync and blank positions, the line and frame lengths, and the colour values for each channel, including zero and full scale. They also show the flag clearing after a clean frame and the raster restarting after a mid-frame reset. For this the bench uses a reduced frame to cover whole frames and a default-sized instance across its first lines.

// File: rtl/xga_raster_expander.sv
module xga_raster_expander #(
  parameter int H_ACT = 1024,
  parameter int H_FP  = 24,
  parameter int H_SW  = 136,
  parameter int H_BP  = 160,
  parameter int V_ACT = 768,
  parameter int V_FP  = 3,
  parameter int V_SW  = 6,
  parameter int V_BP  = 29,
  parameter int CW    = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] px_data,
  input  logic        px_valid,
  output logic        px_ready,
  output logic [29:0] rgb,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic        blank,
  output logic        sof,
  output logic        underflow
);

  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;
  localparam logic [CW-1:0] H_LAST = CW'(H_TOT - 1);
  localparam logic [CW-1:0] V_LAST = CW'(V_TOT - 1);
  localparam logic [CW-1:0] H_VIS  = CW'(H_ACT);
  localparam logic [CW-1:0] V_VIS  = CW'(V_ACT);
  localparam logic [CW-1:0] HS_BEG = CW'(H_ACT + H_FP);
  localparam logic [CW-1:0] HS_END = CW'(H_ACT + H_FP + H_SW);
  localparam logic [CW-1:0] VS_BEG = CW'(V_ACT + V_FP);
  localparam logic [CW-1:0] VS_END = CW'(V_ACT + V_FP + V_SW);

  logic [CW-1:0] hcnt, vcnt;

  wire line_end = (hcnt == H_LAST);
  wire frm_end  = (vcnt == V_LAST);
  wire visible  = (hcnt < H_VIS) && (vcnt < V_VIS);
  wire origin   = (hcnt == '0) && (vcnt == '0);
  wire in_hs    = (hcnt >= HS_BEG) && (hcnt < HS_END);
  wire in_vs    = (vcnt >= VS_BEG) && (vcnt < VS_END);
  wire take     = visible && px_valid;
  wire starve   = visible && !px_valid;

  wire [9:0] red10 = {px_data[15:11], px_data[15:11]};
  wire [9:0] grn10 = {px_data[10:5], px_data[10:7]};
  wire [9:0] blu10 = {px_data[4:0], px_data[4:0]};

  assign px_ready = rst_n && visible;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= line_end ? '0 : hcnt + CW'(1);
      if (line_end) vcnt <= frm_end ? '0 : vcnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_n   <= 1'b1;
      vsync_n   <= 1'b1;
      blank     <= 1'b1;
      sof       <= 1'b0;
      rgb       <= '0;
      underflow <= 1'b0;
    end else begin
      hsync_n   <= !in_hs;
      vsync_n   <= !in_vs;
      blank     <= !visible;
      sof       <= origin;
      rgb       <= take ? {red10, grn10, blu10} : '0;
      underflow <= origin ? !px_valid : (underflow || starve);
    end
  end

  // R8
  sof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !sof);

  // R2
  hsync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> blank);

  // R3
  vsync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> blank);

  // R6
  black_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (rgb == '0));

  // R4
  ready_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_ready |=> !blank);

  // R7
  starve_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_ready && !px_valid) |=> (rgb == '0 && underflow));

  // R7
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (underflow || sof));

endmodule

// File: tb/tb_xga_raster_expander.sv
module tb_raster_model #(
  parameter int HA = 1024, HF = 24, HS = 136, HB = 160,
  parameter int VA = 768,  VF = 3,  VS = 6,   VB = 29
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] d,
  input logic        vld,
  input logic        rdy,
  input logic [29:0] rgb,
  input logic        hs_n,
  input logic        vs_n,
  input logic        bl,
  input logic        sf,
  input logic        uf
);
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  int checks = 0, bad = 0;
  int h = 0, v = 0;
  bit act;
  logic [29:0] e_rgb = '0;
  logic e_hs = 1, e_vs = 1, e_bl = 1, e_sf = 0, e_uf = 0;
  string e_tag = "R9";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h = 0; v = 0; e_rgb = '0; e_hs = 1; e_vs = 1; e_bl = 1; e_sf = 0; e_uf = 0;
    end else begin
      int r, g, b;
      act = (h < HA) && (v < VA);
      r = int'(d[15:11]); g = int'(d[10:5]); b = int'(d[4:0]);
      if (act && vld) begin
        e_rgb = 30'((r * 33) * (1 << 20) + (g * 16 + g / 4) * (1 << 10) + b * 33);
        e_tag = "R5";
      end else begin
        e_rgb = '0;
        e_tag = act ? "R7" : "R6";
      end
      e_hs = !(h >= HA + HF && h < HA + HF + HS);
      e_vs = !(v >= VA + VF && v < VA + VF + VS);
      e_bl = !act;
      e_sf = (h == 0 && v == 0);
      e_uf = e_sf ? !vld : (e_uf || (act && !vld));
      h++;
      if (h == HT) begin
        h = 0; v++;
        if (v == VT) v = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [29:0] got, input logic [29:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s at h=%0d v=%0d: got %h expected %h", tag, h, v, got, exp);
    end
  endtask

  always @(negedge clk) begin
    string rt;
    rt = rst_n ? "" : "R9 ";
    chk({rt, e_tag, " rgb"}, rgb, e_rgb);
    chk({rt, "R2 hsync_n"}, 30'(hs_n), 30'(e_hs));
    chk({rt, "R3 vsync_n"}, 30'(vs_n), 30'(e_vs));
    chk({rt, "R1 blank"}, 30'(bl), 30'(e_bl));
    chk({rt, "R8 sof"}, 30'(sf), 30'(e_sf));
    chk({rt, "R7 underflow"}, 30'(uf), 30'(e_uf));
    chk({rt, "R4 px_ready"}, 30'(rdy), 30'(rst_n && h < HA && v < VA));
  end
endmodule

module tb_xga_raster_expander;
  localparam int CLK_PERIOD = 10;
  localparam int FRM = 16 * 9;

  logic clk = 0, rst_n = 0, px_valid = 1;
  logic [15:0] px_data = 16'h1234;
  logic [29:0] rgb_s, rgb_x;
  logic rdy_s, hs_s, vs_s, bl_s, sf_s, uf_s;
  logic rdy_x, hs_x, vs_x, bl_x, sf_x, uf_x;
  int tb_checks = 0, tb_bad = 0, cyc = 0, mode = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xga_raster_expander #(.H_ACT(8), .H_FP(2), .H_SW(3), .H_BP(3),
                        .V_ACT(4), .V_FP(1), .V_SW(2), .V_BP(2)) dut (
    .clk(clk), .rst_n(rst_n), .px_data(px_data), .px_valid(px_valid),
    .px_ready(rdy_s), .rgb(rgb_s), .hsync_n(hs_s), .vsync_n(vs_s),
    .blank(bl_s), .sof(sf_s), .underflow(uf_s));

  tb_raster_model #(.HA(8), .HF(2), .HS(3), .HB(3), .VA(4), .VF(1), .VS(2), .VB(2)) m_s (
    .clk(clk), .rst_n(rst_n), .d(px_data), .vld(px_valid), .rdy(rdy_s), .rgb(rgb_s),
    .hs_n(hs_s), .vs_n(vs_s), .bl(bl_s), .sf(sf_s), .uf(uf_s));

  xga_raster_expander dut_xga (
    .clk(clk), .rst_n(rst_n), .px_data(px_data), .px_valid(px_valid),
    .px_ready(rdy_x), .rgb(rgb_x), .hsync_n(hs_x), .vsync_n(vs_x),
    .blank(bl_x), .sof(sf_x), .underflow(uf_x));

  tb_raster_model m_x (
    .clk(clk), .rst_n(rst_n), .d(px_data), .vld(px_valid), .rdy(rdy_x), .rgb(rgb_x),
    .hs_n(hs_x), .vs_n(vs_x), .bl(bl_x), .sf(sf_x), .uf(uf_x));

  task automatic tb_chk(input string tag, input int got, input int exp);
    tb_checks++;
    if (got != exp) begin
      tb_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #(CLK_PERIOD / 4);
      cyc++;
      px_data = {px_data[14:0], px_data[15] ^ px_data[13] ^ px_data[12] ^ px_data[10]};
      if (cyc % 17 == 0) px_data = 16'hFFFF;
      if (cyc % 19 == 0) px_data = 16'h0000;
      if (cyc % 23 == 0) px_data = 16'hF800;
      px_valid = (mode == 1) ? (cyc % 5 != 0) : 1'b1;
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d",
             tb_checks + m_s.checks + m_x.checks, tb_bad + m_s.bad + m_x.bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 3 + 2);
    // R9: reset values at the ports
    tb_chk("R9 rgb", int'(rgb_s), 0);
    tb_chk("R9 blank", int'(bl_s), 1);
    tb_chk("R9 px_ready", int'(rdy_s), 0);
    rst_n = 1;
    step(2 * FRM);
    mode = 1;
    step(FRM);
    #(CLK_PERIOD / 4);
    // R7: flag still set at end of a starved frame
    tb_chk("R7 underflow held", int'(uf_s), 1);
    mode = 0;
    step(2 * FRM);
    #(CLK_PERIOD / 4);
    // R7: flag cleared after a clean frame
    tb_chk("R7 underflow cleared", int'(uf_s), 0);
    step(37);
    rst_n = 0;
    step(2);
    rst_n = 1;
    step(3000);
    done = 1;
    summary();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      tb_checks++;
      tb_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule